// File: doc/BRIEF.md
# Address-Decoded NAND Bus Bridge

This block connects a simple request/acknowledge host bus to a raw 8-bit NAND flash device. The host address is split into two regions. In the data window, low address bits choose which NAND control lines are active for the single byte being moved: address latch, command latch, chip select, spare-area and write protect. A command byte is therefore written with chip select and the command latch bit set in the address. An address byte uses chip select and the address latch bit, and data bytes use chip select alone. In the register region, the host reads a status word and reads or writes a control word.

Each data-window access runs one bus cycle through a fixed sequence of phases: setup, strobe, hold and recovery. The strobe lasts two clocks for writes and two for reads by default, and every phase length is a parameter. Only one access is in flight at a time. A sticky completion flag in the status word tells polling software when the cycle has finished, and any new data-window request stalls until that flag is set. The control word enables NAND mode and the chip, sets the active level of several outputs, picks which of two chip-select and ready lines is used, and can narrow chip select to the strobe phase on a shared bus.

Top module: `nand_bus_bridge`

## Requirements
- R1: During a data-window bus cycle (host_addr bit 7 = 0), byte address bit 2 drives the address-latch output, bit 3 the command-latch output, bit 4 chip select, bit 5 the spare-area output and bit 6 write protect; outside a bus cycle the latch outputs are 0 and the other lines sit at their inactive level.
- R2: A data-window cycle is 1 setup clock, then a strobe (write strobe low for 2 clocks on a write, read strobe low for 2 clocks on a read), 1 hold clock and 1 recovery clock; write data is driven with its output enable high from setup through hold.
- R3: Read data is sampled from the NAND data bus on the last clock of the read strobe and returned in host_rdata[7:0] with host_ack in the clock after recovery ends.
- R4: Status word (byte address 0x80) bit 0 shows the selected ready/busy input (1 = ready) and bit 3 shows the completion flag, which clears when a data-window cycle starts and sets once its recovery phase ends.
- R5: A data-window request that arrives while a cycle is running is neither acknowledged nor started until the completion flag is set; register accesses are acknowledged in the same clock at any time.
- R6: The chip-enable output is 1 only when control bit 0 (NAND mode) and control bit 20 (chip enable) are both 1.
- R7: Control bits 4, 5, 6 and 7 give the active level of the chip-select, spare-area, write-protect and pre-charge outputs (1 = active high); the inactive level is the inverse.
- R8: Control bit 10 routes chip select to line 1 instead of line 0, and control bit 8 selects ready input 1 instead of ready input 0 for status bit 0.
- R9: With control bit 1 set, chip select is active only during the strobe phase; with it clear, chip select is active for the whole cycle from setup through recovery.
- R10: After reset the control word is 0, the completion flag reads 1, no strobe, latch or data enable is active and the polarity-controlled outputs sit at 1.
- R11: Control word lives at byte address 0x84 and keeps only bits 0, 1, 4 to 8, 10 and 20 (mask 0x001005F3); other bits read 0, and writes to the status address have no effect.
- R12: The pre-charge output is active during the setup phase of every data-window cycle and inactive otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_req | input | 1 | Host request, held until host_ack |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | 6 | Word address, byte address bits 7:2 |
| host_wdata | input | 32 | Write data (bits 7:0 in the data window) |
| host_ack | output | 1 | Access accepted or read data valid |
| host_rdata | output | 32 | Read data, valid with host_ack |
| nand_rdy_i | input | 2 | Ready/busy inputs, 1 = ready |
| nand_dq_i | input | 8 | NAND data bus input |
| nand_dq_o | output | 8 | NAND data bus output |
| nand_dq_oe | output | 1 | Output enable for nand_dq_o |
| nand_ce_o | output | 1 | Chip enable |
| nand_cs_o | output | 2 | Chip-select lines |
| nand_cle_o | output | 1 | Command latch enable |
| nand_ale_o | output | 1 | Address latch enable |
| nand_se_o | output | 1 | Spare-area select |
| nand_wp_o | output | 1 | Write protect |
| nand_pre_o | output | 1 | Pre-charge strobe |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |

## Verification
The data window is driven with command, address, plain data and spare/write-protect address patterns, so that each address bit is seen to move exactly one output line and no other. The same accesses are repeated under both polarity settings, both chip-select routes and with the strobe-only chip-select mode, which separates a wrong polarity from a wrong line or a wrong phase window. Back-to-back window requests and a status read issued mid-cycle expose when the completion flag clears and sets and how long a second request is held off, and a read whose NAND stub changes its byte every strobe clock shows in which clock the data is captured.

// File: rtl/nand_bridge_pkg.sv
// Package: shared types and bit positions for the NAND bus bridge.
// Assumes a single NAND data path and at most two chip-select lines
// are routed by the control word.
package nand_bridge_pkg;

    // Phases of one data-window bus cycle.
    typedef enum logic [2:0] {
        PH_IDLE   = 3'd0,
        PH_SETUP  = 3'd1,
        PH_STROBE = 3'd2,
        PH_HOLD   = 3'd3,
        PH_RECOV  = 3'd4
    } phase_e;

    // NAND lines requested by the address of a data-window access.
    typedef struct packed {
        logic wp;
        logic se;
        logic cs;
        logic cle;
        logic ale;
    } pin_req_t;

    // Control word bit positions (software visible).
    localparam int CB_MODE    = 0;
    localparam int CB_MUX     = 1;
    localparam int CB_POL_CS  = 4;
    localparam int CB_POL_SE  = 5;
    localparam int CB_POL_WP  = 6;
    localparam int CB_POL_PRE = 7;
    localparam int CB_RDY_SEL = 8;
    localparam int CB_CS_SEL  = 10;
    localparam int CB_CHIP_EN = 20;

    // Bits that the control register actually stores.
    localparam logic [31:0] CTRL_MASK = 32'h0010_05F3;

    // Status word bit positions.
    localparam int SB_READY = 0;
    localparam int SB_DONE  = 3;

    // Word-address bit positions (byte address bit n is word bit n-2).
    localparam int WB_REGION = 5;  // byte bit 7
    localparam int WB_REGSEL = 0;  // byte bit 2 in the register region
    localparam int WB_LINES  = 0;  // byte bits 6:2 in the data window

    // Larger of two integers, for sizing counters.
    function automatic int max_int(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/nand_bridge_regs.sv
// Control and status registers of the NAND bus bridge.
// Holds the masked control word and assembles the read-only status word.
// Assumes the caller qualifies wr_en with a register-region hit.
module nand_bridge_regs
    import nand_bridge_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [DW-1:0] wdata,
    input  logic          done_i,
    input  logic          rdy_i,
    output logic [DW-1:0] ctrl_o,
    output logic [DW-1:0] status_o
);

    localparam logic [DW-1:0] MASK = DW'(CTRL_MASK);

    logic [DW-1:0] ctrl_q;

    // Control register: keeps only the defined bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (wr_en) begin
            ctrl_q <= wdata & MASK;
        end
    end

    // Status word: ready pin and completion flag.
    always_comb begin
        status_o           = '0;
        status_o[SB_READY] = rdy_i;
        status_o[SB_DONE]  = done_i;
    end

    assign ctrl_o = ctrl_q;

endmodule

// File: rtl/nand_bridge_timing.sv
// Bus-cycle timing engine of the NAND bus bridge.
// Steps one accepted access through setup, strobe, hold and recovery,
// latches its lines and write byte, captures read data on the last
// strobe clock and owns the sticky completion flag.
// Assumes start is only raised while the engine is idle and that every
// phase length parameter is at least 1.
module nand_bridge_timing
    import nand_bridge_pkg::*;
#(
    parameter int SETUP_CYC     = 1,
    parameter int WR_STROBE_CYC = 2,
    parameter int RD_STROBE_CYC = 2,
    parameter int HOLD_CYC      = 1,
    parameter int RECOV_CYC     = 1,
    parameter int DQ_W          = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic            start_we,
    input  pin_req_t        start_lines,
    input  logic [DQ_W-1:0] start_wdata,
    input  logic [DQ_W-1:0] dq_i,
    output phase_e          phase_o,
    output logic            done_o,
    output logic            rd_ack_o,
    output logic [DQ_W-1:0] rdata_o,
    output logic            we_o,
    output pin_req_t        lines_o,
    output logic [DQ_W-1:0] wdata_o
);

    localparam int MAXC = max_int(max_int(SETUP_CYC, HOLD_CYC),
                          max_int(RECOV_CYC,
                          max_int(WR_STROBE_CYC, RD_STROBE_CYC)));
    localparam int CW   = $clog2(MAXC) + 1;

    localparam logic [CW-1:0] SETUP_LAST = CW'(SETUP_CYC - 1);
    localparam logic [CW-1:0] WR_LAST    = CW'(WR_STROBE_CYC - 1);
    localparam logic [CW-1:0] RD_LAST    = CW'(RD_STROBE_CYC - 1);
    localparam logic [CW-1:0] HOLD_LAST  = CW'(HOLD_CYC - 1);
    localparam logic [CW-1:0] RECOV_LAST = CW'(RECOV_CYC - 1);

    phase_e          phase_q;
    logic [CW-1:0]   cnt_q;
    logic            done_q;
    logic            rd_ack_q;
    logic [DQ_W-1:0] rdata_q;
    logic            we_q;
    pin_req_t        lines_q;
    logic [DQ_W-1:0] wdata_q;
    logic            last_clk;

    assign last_clk = (cnt_q == '0);

    // Phase sequencer with per-phase down-counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q  <= PH_IDLE;
            cnt_q    <= '0;
            done_q   <= 1'b1;
            rd_ack_q <= 1'b0;
            rdata_q  <= '0;
            we_q     <= 1'b0;
            lines_q  <= '0;
            wdata_q  <= '0;
        end else begin
            rd_ack_q <= 1'b0;
            case (phase_q)
                PH_IDLE: begin
                    if (start) begin
                        phase_q <= PH_SETUP;
                        cnt_q   <= SETUP_LAST;
                        done_q  <= 1'b0;
                        we_q    <= start_we;
                        lines_q <= start_lines;
                        wdata_q <= start_wdata;
                    end
                end
                PH_SETUP: begin
                    if (last_clk) begin
                        phase_q <= PH_STROBE;
                        cnt_q   <= we_q ? WR_LAST : RD_LAST;
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
                PH_STROBE: begin
                    if (last_clk) begin
                        if (!we_q) begin
                            rdata_q <= dq_i;
                        end
                        phase_q <= PH_HOLD;
                        cnt_q   <= HOLD_LAST;
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
                PH_HOLD: begin
                    if (last_clk) begin
                        phase_q <= PH_RECOV;
                        cnt_q   <= RECOV_LAST;
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
                PH_RECOV: begin
                    if (last_clk) begin
                        phase_q  <= PH_IDLE;
                        done_q   <= 1'b1;
                        rd_ack_q <= ~we_q;
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
                default: begin
                    phase_q <= PH_IDLE;
                    done_q  <= 1'b1;
                end
            endcase
        end
    end

    assign phase_o  = phase_q;
    assign done_o   = done_q;
    assign rd_ack_o = rd_ack_q;
    assign rdata_o  = rdata_q;
    assign we_o     = we_q;
    assign lines_o  = lines_q;
    assign wdata_o  = wdata_q;

endmodule

// File: rtl/nand_bridge_pins.sv
// NAND pin driver of the NAND bus bridge.
// Decodes the registered phase and latched line requests into device
// pins, applying polarity, chip-select routing and strobe-only select.
// Assumes all inputs come from flops, so the decoded pins are clean.
module nand_bridge_pins
    import nand_bridge_pkg::*;
#(
    parameter int NCS  = 2,
    parameter int DQ_W = 8
) (
    input  phase_e          phase_i,
    input  pin_req_t        lines_i,
    input  logic            we_i,
    input  logic [DQ_W-1:0] wdata_i,
    input  logic            mux_en,
    input  logic            cs_sel,
    input  logic            pol_cs,
    input  logic            pol_se,
    input  logic            pol_wp,
    input  logic            pol_pre,
    output logic [NCS-1:0]  cs_o,
    output logic            cle_o,
    output logic            ale_o,
    output logic            se_o,
    output logic            wp_o,
    output logic            pre_o,
    output logic            we_n,
    output logic            re_n,
    output logic [DQ_W-1:0] dq_o,
    output logic            dq_oe
);

    logic busy;
    logic strobe;
    logic cs_on;

    // Phase decode shared by all pins.
    always_comb begin
        busy   = (phase_i != PH_IDLE);
        strobe = (phase_i == PH_STROBE);
        cs_on  = lines_i.cs & (mux_en ? strobe : busy);
    end

    // One chip-select line per routing choice.
    for (genvar g = 0; g < NCS; g++) begin : g_cs
        assign cs_o[g] = (cs_on && (int'(cs_sel) == g)) ? pol_cs : ~pol_cs;
    end

    // Latch, area and protect lines, pre-charge and strobes.
    always_comb begin
        cle_o = busy & lines_i.cle;
        ale_o = busy & lines_i.ale;
        se_o  = (busy & lines_i.se) ? pol_se : ~pol_se;
        wp_o  = (busy & lines_i.wp) ? pol_wp : ~pol_wp;
        pre_o = (phase_i == PH_SETUP) ? pol_pre : ~pol_pre;
        we_n  = ~(strobe & we_i);
        re_n  = ~(strobe & ~we_i);
        dq_oe = busy & we_i & (phase_i != PH_RECOV);
        dq_o  = wdata_i;
    end

endmodule

// File: rtl/nand_bus_bridge.sv
// Top of the NAND bus bridge.
// Splits host accesses into the register region and the data window,
// starts one bus cycle per accepted window access and stalls further
// window requests until the completion flag is set.
// Assumes the host holds host_req, host_we, host_addr and host_wdata
// stable until host_ack.
module nand_bus_bridge
    import nand_bridge_pkg::*;
#(
    parameter int AW            = 8,
    parameter int DW            = 32,
    parameter int DQ_W          = 8,
    parameter int NCS           = 2,
    parameter int SETUP_CYC     = 1,
    parameter int WR_STROBE_CYC = 2,
    parameter int RD_STROBE_CYC = 2,
    parameter int HOLD_CYC      = 1,
    parameter int RECOV_CYC     = 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            host_req,
    input  logic            host_we,
    input  logic [AW-3:0]   host_addr,
    input  logic [DW-1:0]   host_wdata,
    output logic            host_ack,
    output logic [DW-1:0]   host_rdata,
    input  logic [NCS-1:0]  nand_rdy_i,
    input  logic [DQ_W-1:0] nand_dq_i,
    output logic [DQ_W-1:0] nand_dq_o,
    output logic            nand_dq_oe,
    output logic            nand_ce_o,
    output logic [NCS-1:0]  nand_cs_o,
    output logic            nand_cle_o,
    output logic            nand_ale_o,
    output logic            nand_se_o,
    output logic            nand_wp_o,
    output logic            nand_pre_o,
    output logic            nand_we_n,
    output logic            nand_re_n
);

    phase_e          phase;
    logic            done;
    logic            rd_ack;
    logic [DQ_W-1:0] rdata;
    logic            cyc_we;
    pin_req_t        cyc_lines;
    logic [DQ_W-1:0] cyc_wdata;
    logic [DW-1:0]   ctrl;
    logic [DW-1:0]   status;
    logic            reg_hit;
    logic            win_hit;
    logic            start;
    logic            ctrl_wr;
    logic            rdy_sel;
    pin_req_t        req_lines;

    // Host decode: region, start of a bus cycle, control write.
    always_comb begin
        reg_hit   = host_req &  host_addr[WB_REGION];
        win_hit   = host_req & ~host_addr[WB_REGION];
        start     = win_hit & (phase == PH_IDLE) & ~rd_ack;
        ctrl_wr   = reg_hit & host_we & host_addr[WB_REGSEL];
        req_lines = pin_req_t'(host_addr[WB_LINES +: 5]);
        rdy_sel   = nand_rdy_i[ctrl[CB_RDY_SEL]];
    end

    // Host response: register reads now, window writes on start, reads on capture.
    always_comb begin
        host_ack   = reg_hit | (start & host_we) | rd_ack;
        host_rdata = '0;
        if (reg_hit && !host_we) begin
            host_rdata = host_addr[WB_REGSEL] ? ctrl : status;
        end else if (rd_ack) begin
            host_rdata = {{(DW-DQ_W){1'b0}}, rdata};
        end
    end

    assign nand_ce_o = ctrl[CB_MODE] & ctrl[CB_CHIP_EN];

    nand_bridge_regs #(
        .DW (DW)
    ) i_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (ctrl_wr),
        .wdata    (host_wdata),
        .done_i   (done),
        .rdy_i    (rdy_sel),
        .ctrl_o   (ctrl),
        .status_o (status)
    );

    nand_bridge_timing #(
        .SETUP_CYC     (SETUP_CYC),
        .WR_STROBE_CYC (WR_STROBE_CYC),
        .RD_STROBE_CYC (RD_STROBE_CYC),
        .HOLD_CYC      (HOLD_CYC),
        .RECOV_CYC     (RECOV_CYC),
        .DQ_W          (DQ_W)
    ) i_timing (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .start_we    (host_we),
        .start_lines (req_lines),
        .start_wdata (host_wdata[DQ_W-1:0]),
        .dq_i        (nand_dq_i),
        .phase_o     (phase),
        .done_o      (done),
        .rd_ack_o    (rd_ack),
        .rdata_o     (rdata),
        .we_o        (cyc_we),
        .lines_o     (cyc_lines),
        .wdata_o     (cyc_wdata)
    );

    nand_bridge_pins #(
        .NCS  (NCS),
        .DQ_W (DQ_W)
    ) i_pins (
        .phase_i (phase),
        .lines_i (cyc_lines),
        .we_i    (cyc_we),
        .wdata_i (cyc_wdata),
        .mux_en  (ctrl[CB_MUX]),
        .cs_sel  (ctrl[CB_CS_SEL]),
        .pol_cs  (ctrl[CB_POL_CS]),
        .pol_se  (ctrl[CB_POL_SE]),
        .pol_wp  (ctrl[CB_POL_WP]),
        .pol_pre (ctrl[CB_POL_PRE]),
        .cs_o    (nand_cs_o),
        .cle_o   (nand_cle_o),
        .ale_o   (nand_ale_o),
        .se_o    (nand_se_o),
        .wp_o    (nand_wp_o),
        .pre_o   (nand_pre_o),
        .we_n    (nand_we_n),
        .re_n    (nand_re_n),
        .dq_o    (nand_dq_o),
        .dq_oe   (nand_dq_oe)
    );

endmodule

// File: rtl/nand_bridge_checker.sv
// Assertion checker for the NAND bus bridge, bound to the top module.
// Relates host handshakes, NAND pins and the timing engine's phase and
// completion flag; strobe widths are measured with counters.
module nand_bridge_checker
    import nand_bridge_pkg::*;
#(
    parameter int AW            = 8,
    parameter int DW            = 32,
    parameter int WR_STROBE_CYC = 2,
    parameter int RD_STROBE_CYC = 2
) (
    input logic          clk,
    input logic          rst_n,
    input logic          host_req,
    input logic          host_we,
    input logic [AW-3:0] host_addr,
    input logic [DW-1:0] host_wdata,
    input logic          host_ack,
    input logic          nand_ce_o,
    input logic          nand_cle_o,
    input logic          nand_ale_o,
    input logic          nand_we_n,
    input logic          nand_re_n,
    input phase_e        phase,
    input logic          done
);

    logic [15:0] wr_low_cnt;
    logic [15:0] rd_low_cnt;

    // Count clocks each strobe has been low.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_low_cnt <= '0;
            rd_low_cnt <= '0;
        end else begin
            wr_low_cnt <= nand_we_n ? '0 : wr_low_cnt + 16'd1;
            rd_low_cnt <= nand_re_n ? '0 : rd_low_cnt + 16'd1;
        end
    end

    // R1: latch lines stay low between bus cycles.
    a_r1_latches_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_IDLE) |-> (!nand_cle_o && !nand_ale_o));

    // R2: write strobe low for exactly the write strobe length.
    a_r2_write_strobe_width: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(nand_we_n) |-> (wr_low_cnt == 16'(WR_STROBE_CYC)));

    // R2: read strobe low for exactly the read strobe length.
    a_r2_read_strobe_width: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(nand_re_n) |-> (rd_low_cnt == 16'(RD_STROBE_CYC)));

    // R2: the two strobes are never low together.
    a_r2_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(!nand_we_n && !nand_re_n));

    // R4: the completion flag rises only out of the recovery phase.
    a_r4_done_after_recovery: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> ($past(phase) == PH_RECOV));

    // R4: while a cycle runs the flag reads 0.
    a_r4_done_low_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (phase != PH_IDLE) |-> !done);

    // R5: no window write is acknowledged while a cycle runs.
    a_r5_no_ack_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (phase != PH_IDLE && host_req && !host_addr[WB_REGION] && host_we) |-> !host_ack);

    // R6: chip enable follows a control write of mode and chip-enable bits.
    a_r6_chip_enable: assert property (@(posedge clk) disable iff (!rst_n)
        (host_req && host_addr[WB_REGION] && host_we && host_addr[WB_REGSEL])
        |=> (nand_ce_o == ($past(host_wdata[CB_MODE]) && $past(host_wdata[CB_CHIP_EN]))));

endmodule

bind nand_bus_bridge nand_bridge_checker #(
    .AW            (AW),
    .DW            (DW),
    .WR_STROBE_CYC (WR_STROBE_CYC),
    .RD_STROBE_CYC (RD_STROBE_CYC)
) i_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_req   (host_req),
    .host_we    (host_we),
    .host_addr  (host_addr),
    .host_wdata (host_wdata),
    .host_ack   (host_ack),
    .nand_ce_o  (nand_ce_o),
    .nand_cle_o (nand_cle_o),
    .nand_ale_o (nand_ale_o),
    .nand_we_n  (nand_we_n),
    .nand_re_n  (nand_re_n),
    .phase      (phase),
    .done       (done)
);

// File: tb/test_nand_bus_bridge.sv
// Bench: behavioural cycle model of the bridge compared every clock,
// plus directed checks on status, stall length, read capture and reset.
module test_nand_bus_bridge;

    localparam int CLK_PERIOD = 10;
    localparam int S_C = 1, W_C = 2, R_C = 2, H_C = 1, V_C = 1;
    localparam logic [31:0] MASK = 32'h0010_05F3;
    localparam logic [7:0] A_STAT = 8'h80, A_CTRL = 8'h84;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_req = 1'b0;
    logic        host_we = 1'b0;
    logic [5:0]  host_addr = '0;
    logic [31:0] host_wdata = '0;
    logic        host_ack;
    logic [31:0] host_rdata;
    logic [1:0]  nand_rdy_i = 2'b01;
    logic [7:0]  nand_dq_i;
    logic [7:0]  nand_dq_o;
    logic        nand_dq_oe, nand_ce_o, nand_cle_o, nand_ale_o;
    logic [1:0]  nand_cs_o;
    logic        nand_se_o, nand_wp_o, nand_pre_o, nand_we_n, nand_re_n;

    int vectors = 0;
    int miscompares = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    nand_bus_bridge i_nand_bus_bridge (
        .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_we(host_we),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_ack(host_ack),
        .host_rdata(host_rdata), .nand_rdy_i(nand_rdy_i), .nand_dq_i(nand_dq_i),
        .nand_dq_o(nand_dq_o), .nand_dq_oe(nand_dq_oe), .nand_ce_o(nand_ce_o),
        .nand_cs_o(nand_cs_o), .nand_cle_o(nand_cle_o), .nand_ale_o(nand_ale_o),
        .nand_se_o(nand_se_o), .nand_wp_o(nand_wp_o), .nand_pre_o(nand_pre_o),
        .nand_we_n(nand_we_n), .nand_re_n(nand_re_n)
    );

    // NAND stub: data byte advances on every clock the read strobe is low.
    logic [7:0] nand_byte = 8'h00;
    logic [7:0] re_cnt;
    always @(posedge clk) re_cnt <= (!rst_n || nand_re_n) ? 8'd0 : re_cnt + 8'd1;
    assign nand_dq_i = nand_byte + re_cnt;

    // Reference model state.
    int          k;
    bit          m_we, m_done, m_rd_ack;
    logic [4:0]  m_lines;
    logic [7:0]  m_wdata, m_rdata;
    logic [31:0] m_ctrl;

    function automatic int cyc_len(bit we);
        return S_C + (we ? W_C : R_C) + H_C + V_C;
    endfunction

    // 0 idle, 1 setup, 2 strobe, 3 hold, 4 recovery
    function automatic int ph_of(int kk, bit we);
        int st = we ? W_C : R_C;
        if (kk < 0) return 0;
        if (kk < S_C) return 1;
        if (kk < S_C + st) return 2;
        if (kk < S_C + st + H_C) return 3;
        return 4;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            k = -1; m_we = 0; m_done = 1; m_rd_ack = 0;
            m_lines = '0; m_wdata = '0; m_rdata = '0; m_ctrl = '0;
        end else begin
            bit st, rd_next;
            st = host_req && !host_addr[5] && k < 0 && !m_rd_ack;
            rd_next = 0;
            if (host_req && host_addr[5] && host_we && host_addr[0])
                m_ctrl = host_wdata & MASK;
            if (k >= 0) begin
                if (!m_we && k == S_C + R_C - 1) m_rdata = nand_dq_i;
                rd_next = (k == cyc_len(m_we) - 1) && !m_we;
                k++;
                if (k == cyc_len(m_we)) begin k = -1; m_done = 1; end
            end
            if (st) begin
                k = 0; m_done = 0; m_we = host_we;
                m_lines = host_addr[4:0]; m_wdata = host_wdata[7:0];
            end
            m_rd_ack = rd_next;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s act=%h exp=%h at %0t", req, act, exp, $time);
        end
    endtask

    // Every-clock comparison of all outputs against the model.
    always @(negedge clk) begin
        if (rst_n) begin
            int  p;
            bit  busy, strb, cs_on, pol, reg_hit, st;
            logic [31:0] e_rd, e_stat;
            logic [1:0]  e_cs;
            p     = ph_of(k, m_we);
            busy  = (p != 0);
            strb  = (p == 2);
            chk("R1 latch lines", {30'b0, nand_cle_o, nand_ale_o},
                {30'b0, busy & m_lines[1], busy & m_lines[0]});
            chk("R1 R7 spare/protect", {30'b0, nand_se_o, nand_wp_o},
                {30'b0, (busy & m_lines[3]) ? m_ctrl[5] : ~m_ctrl[5],
                        (busy & m_lines[4]) ? m_ctrl[6] : ~m_ctrl[6]});
            chk("R2 strobes/dq enable", {29'b0, nand_we_n, nand_re_n, nand_dq_oe},
                {29'b0, ~(strb & m_we), ~(strb & ~m_we), busy & m_we & (p != 4)});
            if (nand_dq_oe) chk("R2 write byte", {24'b0, nand_dq_o}, {24'b0, m_wdata});
            pol   = m_ctrl[4];
            cs_on = m_lines[2] & (m_ctrl[1] ? strb : busy);
            e_cs[0] = (cs_on && !m_ctrl[10]) ? pol : ~pol;
            e_cs[1] = (cs_on &&  m_ctrl[10]) ? pol : ~pol;
            chk("R7 R8 R9 chip select", {30'b0, nand_cs_o}, {30'b0, e_cs});
            chk("R7 R12 pre-charge", {31'b0, nand_pre_o},
                {31'b0, (p == 1) ? m_ctrl[7] : ~m_ctrl[7]});
            chk("R6 chip enable", {31'b0, nand_ce_o}, {31'b0, m_ctrl[0] & m_ctrl[20]});
            reg_hit = host_req && host_addr[5];
            st      = host_req && !host_addr[5] && k < 0 && !m_rd_ack;
            e_stat  = {28'b0, m_done, 2'b0, nand_rdy_i[m_ctrl[8]]};
            e_rd    = 32'b0;
            if (reg_hit && !host_we) e_rd = host_addr[0] ? m_ctrl : e_stat;
            else if (m_rd_ack) e_rd = {24'b0, m_rdata};
            chk("R3 R5 R11 host ack", {31'b0, host_ack},
                {31'b0, reg_hit | (st & host_we) | m_rd_ack});
            chk("R3 R4 R11 host rdata", host_rdata, e_rd);
        end
    end

    // One host access; returns read data and clocks spent waiting.
    task automatic host_xfer(input bit we, input logic [7:0] addr, input logic [31:0] wd,
                             output logic [31:0] rd, output int waited);
        @(posedge clk); #1;
        host_req = 1; host_we = we; host_addr = addr[7:2]; host_wdata = wd;
        waited = 0;
        forever begin
            @(negedge clk);
            if (host_ack) begin rd = host_rdata; break; end
            waited++;
        end
        @(posedge clk); #1;
        host_req = 0; host_we = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        vectors++; miscompares++;
        $display("FAIL R5 watchdog act=hung exp=finished");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin : stimulus
        logic [31:0] rd;
        int w;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R10: reset state of the pins.
        chk("R10 reset cs", {30'b0, nand_cs_o}, 32'h3);
        chk("R10 reset strobes/latches",
            {26'b0, nand_we_n, nand_re_n, nand_dq_oe, nand_cle_o, nand_ale_o, nand_ce_o},
            {26'b0, 6'b110000});
        chk("R10 reset se/wp/pre", {29'b0, nand_se_o, nand_wp_o, nand_pre_o}, 32'h7);
        @(posedge clk); #1 rst_n = 1;
        host_xfer(0, A_STAT, 0, rd, w);
        chk("R10 R4 status after reset", rd, 32'h9);
        host_xfer(0, A_CTRL, 0, rd, w);
        chk("R10 control after reset", rd, 32'h0);

        // R6: chip enable needs both bits.
        host_xfer(1, A_CTRL, 32'h0000_0001, rd, w);
        @(negedge clk); chk("R6 mode only", {31'b0, nand_ce_o}, 32'h0);
        host_xfer(1, A_CTRL, 32'h0010_0001, rd, w);
        @(negedge clk); chk("R6 mode and chip", {31'b0, nand_ce_o}, 32'h1);

        // R1 R4: command byte, status sampled mid-cycle then after.
        host_xfer(1, 8'h18, 32'h90, rd, w);
        host_xfer(0, A_STAT, 0, rd, w);
        chk("R4 done clear while busy", {31'b0, rd[3]}, 32'h0);
        idle(6);
        host_xfer(0, A_STAT, 0, rd, w);
        chk("R4 done set after recovery", {31'b0, rd[3]}, 32'h1);

        // R5: second address byte stalls until the first finishes.
        host_xfer(1, 8'h14, 32'h12, rd, w);
        host_xfer(1, 8'h14, 32'h34, rd, w);
        chk("R5 stall clocks", w, cyc_len(1) - 1);
        idle(6);

        // R3: read sampled on last strobe clock.
        nand_byte = 8'h5A;
        host_xfer(0, 8'h10, 0, rd, w);
        chk("R3 read byte", rd, 32'h0000_0000 | (8'h5A + R_C - 1));
        idle(2);

        // R1: spare area and write protect lines.
        host_xfer(1, 8'h70, 32'hA5, rd, w);
        idle(6);

        // R7 R12: flip all polarities.
        host_xfer(1, A_CTRL, 32'h0010_00F1, rd, w);
        @(negedge clk); chk("R7 cs idle high-active", {30'b0, nand_cs_o}, 32'h0);
        host_xfer(1, 8'h7C, 32'h3C, rd, w);
        idle(6);

        // R8: route chip select and ready to line 1.
        nand_rdy_i = 2'b10;
        host_xfer(0, A_STAT, 0, rd, w);
        chk("R8 ready line 0", {31'b0, rd[0]}, 32'h0);
        host_xfer(1, A_CTRL, 32'h0010_0501, rd, w);
        host_xfer(0, A_STAT, 0, rd, w);
        chk("R8 ready line 1", {31'b0, rd[0]}, 32'h1);
        host_xfer(1, 8'h10, 32'h77, rd, w);
        idle(6);
        nand_byte = 8'hC0;
        host_xfer(0, 8'h30, 0, rd, w);
        chk("R3 second read", rd, 32'h0000_0000 | (8'hC0 + R_C - 1));
        idle(2);

        // R9: chip select only during strobe.
        host_xfer(1, A_CTRL, 32'h0010_0003, rd, w);
        host_xfer(1, 8'h18, 32'hFF, rd, w);
        idle(6);
        host_xfer(0, 8'h14, 0, rd, w);
        idle(2);

        // R11: masked control and ignored status write.
        host_xfer(1, A_CTRL, 32'hFFFF_FFFF, rd, w);
        host_xfer(0, A_CTRL, 0, rd, w);
        chk("R11 control mask", rd, MASK);
        host_xfer(1, A_STAT, 32'h0000_0000, rd, w);
        host_xfer(0, A_CTRL, 0, rd, w);
        chk("R11 status write ignored ctrl", rd, MASK);
        host_xfer(0, A_STAT, 0, rd, w);
        chk("R11 status write ignored stat", rd, 32'h9);
        host_xfer(1, 8'h7C, 32'h5A, rd, w);
        idle(8);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule